// File: doc/BRIEF.md
# Measurement Counter Host Control Interface

This block sits between a host processor and a measurement counter. The host drives a set of single-purpose strobe lines. Each line asks for one action: clear the counter stages, restart the readback sequence, shift one serial bit into a configuration shift register, copy that register into the configuration outputs, or capture a parallel control word. Every strobe line is first passed through a synchronizer into the block clock. A line acts once, on its rising edge, no matter how long the host holds it high.

The configuration latch drives two fields: an input selector code and a divider exponent. For readback, a step sequencer splits the wide count result into byte-wide buffers. It puts one buffer at a time on the host data bus and moves to the next only when the host asks for it. After the last buffer the bus reads zero until the sequence is restarted. The serial data line goes through the same synchronizer depth as the shift strobe. Data that is set up when the strobe rises is therefore the bit that gets captured.

Top module: `cnt_host_ctrl`

## Requirements
- R1: After reset all buffer enables are 0, the read bus is 0, the selector, exponent and control outputs are 0, and the clear output is low.
- R2: Each strobe line acts exactly once per rising edge, however long it stays high. The output reflecting the action changes on the third clock edge after the line rises: two synchronizer stages, then the action register.
- R3: A rising edge on the clear line produces a count_clear_o pulse exactly one clock cycle wide.
- R4: A rising edge on the shift line moves the synchronized serial bit into bit 0 of the shift register, and the older bits move one place toward the MSB. Shifting alone leaves the selector and exponent outputs unchanged.
- R5: A rising edge on the configuration load line copies the shift register to the outputs. The upper SEL_W bits go to sel_o and the lower EXP_W bits go to exp_o. The outputs hold until the next load.
- R6: A rising edge on the control load line captures ctl_word_i into ctl_o. Changes on ctl_word_i without that edge do not reach ctl_o.
- R7: A rising edge on the sequence restart line selects buffer 0: buf_en_o = 1 and rd_data_o = count_i[7:0]. If a next request edge arrives in the same cycle, the restart takes precedence.
- R8: Each rising edge on the next request line advances the sequencer by exactly one buffer. Buffer k shows count bits 8k to 8k+7, and bits above COUNT_W read as 0.
- R9: At most one bit of buf_en_o is ever set.
- R10: After the last buffer, and after reset, buf_en_o is 0 and rd_data_o is 0. Further requests change nothing until the next restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clear_stb_i | input | 1 | Strobe: clear counter stages |
| seq_rst_stb_i | input | 1 | Strobe: restart readback sequence |
| shift_clk_i | input | 1 | Strobe: shift one serial bit |
| ser_data_i | input | 1 | Serial configuration data |
| cfg_load_stb_i | input | 1 | Strobe: load configuration outputs |
| ctl_load_stb_i | input | 1 | Strobe: capture control word |
| ctl_word_i | input | CTL_W | Parallel control word |
| next_req_i | input | 1 | Strobe: advance to next readback buffer |
| count_i | input | COUNT_W | Count result from the counter |
| count_clear_o | output | 1 | One-cycle clear pulse to the counter |
| sel_o | output | SEL_W | Latched input selector code |
| exp_o | output | EXP_W | Latched divider exponent |
| ctl_o | output | CTL_W | Latched control word |
| buf_en_o | output | NBUF | One-hot readback buffer enable |
| rd_data_o | output | BYTE_W | Host read bus |

## Verification
Every one of the 128 configuration words is shifted in MSB first and loaded. This shows whether the selector and exponent fields are split and ordered correctly. Before each load, the previous word is checked again, which separates shifting from loading. The readback is walked over all-zero, all-one, alternating and mixed count values. These show the byte order, the zero padding above the count width, and the idle bus after the last buffer. Strobes held high for many cycles, and restart and request edges arriving together, separate edge action from level action and show which of the two edges wins.

// File: rtl/chc_pkg.sv
package chc_pkg;

   // Index of each host line inside the synchronizer vector.
   localparam int L_CLEAR  = 0;
   localparam int L_SEQRST = 1;
   localparam int L_SHIFT  = 2;
   localparam int L_CFG    = 3;
   localparam int L_CTL    = 4;
   localparam int L_REQ    = 5;
   localparam int L_DATA   = 6;
   localparam int N_LINES  = 7;

   // Lines whose rising edge is an event; the rest are passed as levels.
   localparam logic [N_LINES-1:0] LINE_EDGE_MASK = 7'b011_1111;

   function automatic int buf_count(input int count_w, input int byte_w);
      return (count_w + byte_w - 1) / byte_w;
   endfunction

endpackage

// File: rtl/chc_line_sync.sv
module chc_line_sync #(
   parameter int N      = 1,
   parameter int STAGES = 2,
   parameter logic [N-1:0] EDGE_MASK = '1
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic [N-1:0] raw_i,
   output logic [N-1:0] ev_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("chc_line_sync: STAGES must be at least 2");
   end

   for (genvar gi = 0; gi < N; gi++) begin : g_line
      logic [STAGES-1:0] sync_q;

      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) sync_q <= '0;
         else         sync_q <= {sync_q[STAGES-2:0], raw_i[gi]};
      end

      if (EDGE_MASK[gi]) begin : g_edge
         logic prev_q;
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) prev_q <= 1'b0;
            else         prev_q <= sync_q[STAGES-1];
         end
         assign ev_o[gi] = sync_q[STAGES-1] & ~prev_q;

         // R2: an edge event never lasts more than one cycle
         a_r2_single_event: assert property (@(posedge clk_i) disable iff (!rst_ni)
            ev_o[gi] |=> !ev_o[gi]);
      end else begin : g_level
         assign ev_o[gi] = sync_q[STAGES-1];
      end
   end

endmodule

// File: rtl/chc_cfg_loader.sv
module chc_cfg_loader #(
   parameter int SEL_W = 3,
   parameter int EXP_W = 4,
   localparam int CFG_W = SEL_W + EXP_W
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             shift_i,
   input  logic             bit_i,
   input  logic             load_i,
   output logic [SEL_W-1:0] sel_o,
   output logic [EXP_W-1:0] exp_o
);

   logic [CFG_W-1:0] shreg_q;
   logic [CFG_W-1:0] cfg_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      shreg_q <= '0;
      else if (shift_i) shreg_q <= {shreg_q[CFG_W-2:0], bit_i};
   end

   // A load in the same cycle as a shift takes the pre-shift contents.
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     cfg_q <= '0;
      else if (load_i) cfg_q <= shreg_q;
   end

   assign {sel_o, exp_o} = cfg_q;

   a_r4_shift_in: assert property (@(posedge clk_i) disable iff (!rst_ni)
      shift_i |=> shreg_q[0] == $past(bit_i));

   a_r5_load_copy: assert property (@(posedge clk_i) disable iff (!rst_ni)
      load_i |=> cfg_q == $past(shreg_q));

   a_r5_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !load_i |=> $stable(cfg_q));

endmodule

// File: rtl/chc_readback_seq.sv
module chc_readback_seq #(
   parameter int COUNT_W = 21,
   parameter int BYTE_W  = 8,
   localparam int NBUF   = chc_pkg::buf_count(COUNT_W, BYTE_W),
   localparam int STEP_W = $clog2(NBUF + 1)
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               restart_i,
   input  logic               advance_i,
   input  logic [COUNT_W-1:0] count_i,
   output logic [NBUF-1:0]    buf_en_o,
   output logic [BYTE_W-1:0]  data_o
);

   localparam logic [STEP_W-1:0] DONE = STEP_W'(NBUF);

   logic [STEP_W-1:0]      step_q;
   logic [NBUF*BYTE_W-1:0] padded;
   logic [BYTE_W-1:0]      masked [NBUF];

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                           step_q <= DONE;
      else if (restart_i)                    step_q <= '0;
      else if (advance_i && step_q != DONE)  step_q <= step_q + 1'b1;
   end

   assign padded = (NBUF*BYTE_W)'(count_i);

   for (genvar gb = 0; gb < NBUF; gb++) begin : g_buf
      assign buf_en_o[gb] = (step_q == STEP_W'(gb));
      assign masked[gb]   = buf_en_o[gb] ? padded[gb*BYTE_W +: BYTE_W] : '0;
   end

   always_comb begin
      data_o = '0;
      for (int i = 0; i < NBUF; i++) data_o |= masked[i];
   end

   a_r7_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
      restart_i |=> buf_en_o[0]);

   a_r8_one_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (advance_i && !restart_i && step_q != DONE) |=> step_q == STEP_W'($past(step_q) + 1'b1));

   a_r9_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(buf_en_o));

   a_r10_idle_bus: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (buf_en_o == '0) |-> (data_o == '0));

   a_r10_stay_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (step_q == DONE && !restart_i) |=> step_q == DONE);

endmodule

// File: rtl/cnt_host_ctrl.sv
module cnt_host_ctrl
   import chc_pkg::*;
#(
   parameter int SEL_W       = 3,
   parameter int EXP_W       = 4,
   parameter int CTL_W       = 8,
   parameter int COUNT_W     = 21,
   parameter int BYTE_W      = 8,
   parameter int SYNC_STAGES = 2,
   localparam int NBUF       = chc_pkg::buf_count(COUNT_W, BYTE_W)
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               clear_stb_i,
   input  logic               seq_rst_stb_i,
   input  logic               shift_clk_i,
   input  logic               ser_data_i,
   input  logic               cfg_load_stb_i,
   input  logic               ctl_load_stb_i,
   input  logic [CTL_W-1:0]   ctl_word_i,
   input  logic               next_req_i,
   input  logic [COUNT_W-1:0] count_i,
   output logic               count_clear_o,
   output logic [SEL_W-1:0]   sel_o,
   output logic [EXP_W-1:0]   exp_o,
   output logic [CTL_W-1:0]   ctl_o,
   output logic [NBUF-1:0]    buf_en_o,
   output logic [BYTE_W-1:0]  rd_data_o
);

   if (SEL_W < 1 || EXP_W < 1) begin : g_bad_cfg
      $error("cnt_host_ctrl: SEL_W and EXP_W must be at least 1");
   end
   if (CTL_W < 1 || COUNT_W < 1 || BYTE_W < 1) begin : g_bad_width
      $error("cnt_host_ctrl: widths must be at least 1");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("cnt_host_ctrl: SYNC_STAGES must be at least 2");
   end

   logic [N_LINES-1:0] raw;
   logic [N_LINES-1:0] ev;
   logic               clr_q;
   logic [CTL_W-1:0]   ctl_q;

   assign raw[L_CLEAR]  = clear_stb_i;
   assign raw[L_SEQRST] = seq_rst_stb_i;
   assign raw[L_SHIFT]  = shift_clk_i;
   assign raw[L_CFG]    = cfg_load_stb_i;
   assign raw[L_CTL]    = ctl_load_stb_i;
   assign raw[L_REQ]    = next_req_i;
   assign raw[L_DATA]   = ser_data_i;

   chc_line_sync #(
      .N         (N_LINES),
      .STAGES    (SYNC_STAGES),
      .EDGE_MASK (LINE_EDGE_MASK)
   ) u_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .raw_i  (raw),
      .ev_o   (ev)
   );

   chc_cfg_loader #(
      .SEL_W (SEL_W),
      .EXP_W (EXP_W)
   ) u_cfg (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .shift_i (ev[L_SHIFT]),
      .bit_i   (ev[L_DATA]),
      .load_i  (ev[L_CFG]),
      .sel_o   (sel_o),
      .exp_o   (exp_o)
   );

   chc_readback_seq #(
      .COUNT_W (COUNT_W),
      .BYTE_W  (BYTE_W)
   ) u_seq (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .restart_i (ev[L_SEQRST]),
      .advance_i (ev[L_REQ]),
      .count_i   (count_i),
      .buf_en_o  (buf_en_o),
      .data_o    (rd_data_o)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) clr_q <= 1'b0;
      else         clr_q <= ev[L_CLEAR];
   end
   assign count_clear_o = clr_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)          ctl_q <= '0;
      else if (ev[L_CTL])   ctl_q <= ctl_word_i;
   end
   assign ctl_o = ctl_q;

   a_r3_clear_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
      count_clear_o |=> !count_clear_o);

   a_r6_ctl_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !ev[L_CTL] |=> $stable(ctl_o));

   a_r6_ctl_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ev[L_CTL] |=> ctl_o == $past(ctl_word_i));

endmodule

// File: tb/cnt_host_ctrl_test.sv
`timescale 1ns/1ps
module cnt_host_ctrl_test;

   localparam int SEL_W = 3, EXP_W = 4, CTL_W = 8, COUNT_W = 21, BYTE_W = 8, NBUF = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic clear_stb = 0, seq_rst = 0, shift_clk = 0, ser_data = 0;
   logic cfg_load = 0, ctl_load = 0, next_req = 0;
   logic [CTL_W-1:0]   ctl_word = '0;
   logic [COUNT_W-1:0] count = '0;
   logic               count_clear;
   logic [SEL_W-1:0]   sel;
   logic [EXP_W-1:0]   expo;
   logic [CTL_W-1:0]   ctl;
   logic [NBUF-1:0]    buf_en;
   logic [BYTE_W-1:0]  rd_data;

   int n_cmp = 0, n_bad = 0, clr_cycles = 0;

   always #4 clk = ~clk;

   cnt_host_ctrl uut (
      .clk_i(clk), .rst_ni(rst_n), .clear_stb_i(clear_stb), .seq_rst_stb_i(seq_rst),
      .shift_clk_i(shift_clk), .ser_data_i(ser_data), .cfg_load_stb_i(cfg_load),
      .ctl_load_stb_i(ctl_load), .ctl_word_i(ctl_word), .next_req_i(next_req),
      .count_i(count), .count_clear_o(count_clear), .sel_o(sel), .exp_o(expo),
      .ctl_o(ctl), .buf_en_o(buf_en), .rd_data_o(rd_data));

   always @(negedge clk) if (rst_n && count_clear) clr_cycles++;

   task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic report();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   task automatic drive(input int w, input logic v);
      case (w)
         0: clear_stb = v;
         1: seq_rst   = v;
         2: shift_clk = v;
         3: cfg_load  = v;
         4: ctl_load  = v;
         default: next_req = v;
      endcase
   endtask

   task automatic pulse(input int w);
      @(negedge clk); drive(w, 1'b1);
      repeat (4) @(negedge clk);
      drive(w, 1'b0);
      repeat (4) @(negedge clk);
   endtask

   function automatic logic [7:0] byte_of(input logic [COUNT_W-1:0] c, input int k);
      logic [31:0] wide;
      wide = 32'(c);
      return wide[k*8 +: 8];
   endfunction

   initial begin
      #(8 * 150000);
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      report();
   end

   initial begin
      logic [COUNT_W-1:0] pats [6];
      pats[0] = '0; pats[1] = '1; pats[2] = 21'h15_5555; pats[3] = 21'h0A_AAAA;
      pats[4] = 21'h15_A5C3; pats[5] = 21'h10_0001;

      repeat (3) @(negedge clk);
      // R1: reset state
      check("R1", "buf_en", 32'(buf_en), 0);
      check("R1", "rd_data", 32'(rd_data), 0);
      check("R1", "sel", 32'(sel), 0);
      check("R1", "exp", 32'(expo), 0);
      check("R1", "ctl", 32'(ctl), 0);
      check("R1", "clear", 32'(count_clear), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R4 R5: sweep every configuration word, MSB first
      for (int v = 0; v < 128; v++) begin
         for (int b = 6; b >= 0; b--) begin
            @(negedge clk); ser_data = v[b];
            pulse(2);
         end
         if (v > 0) begin
            check("R4", "sel unchanged by shift", 32'(sel), 32'((v - 1) >> 4));
            check("R4", "exp unchanged by shift", 32'(expo), 32'((v - 1) & 15));
         end
         pulse(3);
         check("R5", "sel", 32'(sel), 32'(v >> 4));
         check("R5", "exp", 32'(expo), 32'(v & 15));
      end

      // R3: clear held high gives one single-cycle pulse
      clr_cycles = 0;
      @(negedge clk); clear_stb = 1'b1;
      repeat (12) @(negedge clk);
      clear_stb = 1'b0;
      repeat (4) @(negedge clk);
      check("R3", "clear cycles", 32'(clr_cycles), 1);
      pulse(0);
      check("R3", "clear cycles second", 32'(clr_cycles), 2);

      // R6: control word capture and hold
      for (int i = 0; i < 4; i++) begin
         logic [7:0] w;
         w = (i == 0) ? 8'hA5 : (i == 1) ? 8'h3C : (i == 2) ? 8'hFF : 8'h00;
         ctl_word = w;
         pulse(4);
         check("R6", "ctl", 32'(ctl), 32'(w));
         ctl_word = ~w;
         repeat (6) @(negedge clk);
         check("R6", "ctl without strobe", 32'(ctl), 32'(w));
      end

      // R10: before any restart the bus is idle
      check("R10", "idle buf_en", 32'(buf_en), 0);
      pulse(5);
      check("R10", "request when idle", 32'(buf_en), 0);

      // R7 R8 R9 R10: walk the readback with several count patterns
      for (int p = 0; p < 6; p++) begin
         count = pats[p];
         pulse(1);
         check("R7", "restart buf_en", 32'(buf_en), 1);
         check("R7", "byte0", 32'(rd_data), 32'(byte_of(count, 0)));
         for (int k = 1; k < NBUF; k++) begin
            pulse(5);
            check("R8", "buf_en step", 32'(buf_en), 32'(1 << k));
            check("R8", "byte", 32'(rd_data), 32'(byte_of(count, k)));
         end
         pulse(5);
         check("R10", "done buf_en", 32'(buf_en), 0);
         check("R10", "done data", 32'(rd_data), 0);
         pulse(5);
         check("R10", "extra request buf_en", 32'(buf_en), 0);
         check("R10", "extra request data", 32'(rd_data), 0);
      end

      // R2: latency of three edges and single action while held
      count = 21'h1F_0F0F;
      pulse(1);
      @(negedge clk); next_req = 1'b1;
      @(negedge clk); check("R2", "after edge 1", 32'(buf_en), 1);
      @(negedge clk); check("R2", "after edge 2", 32'(buf_en), 1);
      @(negedge clk); check("R2", "after edge 3", 32'(buf_en), 2);
      repeat (10) @(negedge clk);
      check("R2", "held request", 32'(buf_en), 2);
      check("R9", "held request data", 32'(rd_data), 32'(byte_of(count, 1)));
      next_req = 1'b0;
      repeat (4) @(negedge clk);

      // R7: restart wins over a simultaneous request
      @(negedge clk); seq_rst = 1'b1; next_req = 1'b1;
      repeat (4) @(negedge clk);
      seq_rst = 1'b0; next_req = 1'b0;
      repeat (4) @(negedge clk);
      check("R7", "restart priority", 32'(buf_en), 1);
      check("R7", "restart priority data", 32'(rd_data), 32'(byte_of(count, 0)));

      report();
   end

endmodule